// File: doc/BRIEF.md
# Tone Transceiver Status Flags and Interrupt Pin

This block keeps the four status flags of a tone signalling transceiver. It also drives the single active-low pin that either signals an interrupt or, for diagnosis, shows the receiver's steering condition. The surrounding transceiver feeds it single-cycle event strobes. One strobe says the transmitter has finished a burst and its pause. One says a received digit has been latched. Two more say the detector has validated a tone or validated that the line is quiet. The block also takes a strobe for each status read and the mode bits that software programmed.

Each flag follows its own rule. Some flags clear when software reads the status. One clears when burst operation is switched off. The steering flag tracks the detector alone and ignores reads. The interrupt flag gathers the transmit and receive events. A read returns the flags as they were before it, and the clear lands on the following clock edge. If a set event and a read coincide, the set is kept, so no event is lost.

The pin is driven from the current flag state and the mode bits without a further register. In normal operation it goes low while an interrupt is pending and interrupts are enabled. With the diagnostic mode on, and the dual-tone mode selected, it instead shows the inverted steering flag.

Top module: `xcvr_flag_unit`

## Requirements
- R1: While and after synchronous reset `rst` is high, `status_o` is 4'b0000 and `irq_pin_n_o` is 1.
- R2: A cycle with `rx_load_i`=1 sets `status_o[2]` (receive full) and `status_o[0]` (interrupt) at the next clock edge.
- R3: A cycle with `tx_done_i`=1 and `burst_en_i`=1 sets `status_o[1]` (transmit empty) and `status_o[0]` at the next edge. With `burst_en_i`=0, `tx_done_i` leaves `status_o` unchanged.
- R4: Any cycle with `burst_en_i`=0 clears `status_o[1]` at the next edge and leaves `status_o[0]` as it was.
- R5: A cycle with `rd_stb_i`=1 does not change `status_o` during that cycle. It clears `status_o[2:0]` at the next edge.
- R6: When a set event for bit 0, 1 or 2 occurs in the same cycle as `rd_stb_i`, that bit and bit 0 are set after the edge. The other bits of 2:0 are cleared.
- R7: `quiet_ok_i`=1 sets `status_o[3]` (steering) and `tone_ok_i`=1 clears it at the next edge. If both are high, the set wins. `rd_stb_i` never changes bit 3.
- R8: When the diagnostic mode is not in effect, `irq_pin_n_o` is 0 exactly when `irq_en_i`=1 and `status_o[0]`=1, and is 1 otherwise.
- R9: With `test_en_i`=1 and `cp_sel_i`=0, `irq_pin_n_o` equals the inverse of `status_o[3]`, whatever `irq_en_i` is.
- R10: With `cp_sel_i`=1, `test_en_i` has no effect and the pin follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done_i | input | 1 | Strobe: burst and its pause have finished |
| rx_load_i | input | 1 | Strobe: valid received data loaded |
| quiet_ok_i | input | 1 | Strobe: detector validated absence of tone |
| tone_ok_i | input | 1 | Strobe: detector validated a tone |
| rd_stb_i | input | 1 | Strobe: status word is being read |
| burst_en_i | input | 1 | 1 selects timed burst operation |
| irq_en_i | input | 1 | 1 lets the interrupt reach the pin |
| test_en_i | input | 1 | 1 requests the diagnostic pin function |
| cp_sel_i | input | 1 | 1 selects call-progress mode, 0 dual-tone mode |
| status_o | output | 4 | Flags: 3 steering, 2 receive full, 1 transmit empty, 0 interrupt |
| irq_pin_n_o | output | 1 | Active-low interrupt or diagnostic pin |

## Verification
Every flag result is due one clock edge after the strobe that causes it. The pin is due in the same cycle as a flag or mode change, because it has no register of its own. The bench drives inputs on the falling edge and checks flags on the next falling edge, after exactly one rising edge. Read-value and pin checks are taken a short delay after the inputs change, before any rising edge.

// File: rtl/xcvr_flag_pkg.sv
package xcvr_flag_pkg;

    localparam int STAT_W   = 4;
    localparam int BIT_IRQ  = 0;
    localparam int BIT_TXE  = 1;
    localparam int BIT_RXF  = 2;
    localparam int BIT_STR  = 3;

    // Field order follows the bit positions software decodes.
    typedef struct packed {
        logic steer;
        logic rx_full;
        logic tx_empty;
        logic irq;
    } stat_t;

    typedef enum logic {
        PIN_FROM_IRQ   = 1'b0,
        PIN_FROM_STEER = 1'b1
    } pin_src_e;

    typedef struct packed {
        logic burst;
        logic irq_en;
        logic test;
        logic cp;
    } mode_t;

    // Set has priority over clear so an event is never lost.
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        logic n;
        n = cur;
        if (clr) n = 1'b0;
        if (set) n = 1'b1;
        return n;
    endfunction

    function automatic pin_src_e pick_source(input mode_t m);
        return (m.test && !m.cp) ? PIN_FROM_STEER : PIN_FROM_IRQ;
    endfunction

endpackage

// File: rtl/xcvr_event_decode.sv
module xcvr_event_decode
    import xcvr_flag_pkg::*;
(
    input  logic  tx_done,
    input  logic  rx_load,
    input  logic  quiet_ok,
    input  logic  tone_ok,
    input  logic  rd_stb,
    input  mode_t mode,
    output stat_t set_v,
    output stat_t clr_v
);
    logic tx_evt;

    always_comb begin
        tx_evt         = tx_done && mode.burst;
        set_v          = '0;
        clr_v          = '0;
        set_v.rx_full  = rx_load;
        set_v.tx_empty = tx_evt;
        set_v.irq      = rx_load || tx_evt;
        set_v.steer    = quiet_ok;
        clr_v.rx_full  = rd_stb;
        clr_v.tx_empty = rd_stb || !mode.burst;
        clr_v.irq      = rd_stb;
        clr_v.steer    = tone_ok;
    end
endmodule

// File: rtl/xcvr_flag_bank.sv
module xcvr_flag_bank
    import xcvr_flag_pkg::*;
#(
    parameter int                 W       = STAT_W,
    parameter logic [STAT_W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) q[i] <= RST_VAL[i];
            else     q[i] <= flag_next(q[i], set_v[i], clr_v[i]);
        end
    end
endmodule

// File: rtl/xcvr_pin_mux.sv
module xcvr_pin_mux
    import xcvr_flag_pkg::*;
(
    input  stat_t st,
    input  mode_t mode,
    output logic  pin_n
);
    pin_src_e src;

    always_comb begin
        src = pick_source(mode);
        unique case (src)
            PIN_FROM_STEER: pin_n = !st.steer;
            default:        pin_n = !(mode.irq_en && st.irq);
        endcase
    end
endmodule

// File: rtl/xcvr_flag_unit.sv
module xcvr_flag_unit
    import xcvr_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_done_i,
    input  logic             rx_load_i,
    input  logic             quiet_ok_i,
    input  logic             tone_ok_i,
    input  logic             rd_stb_i,
    input  logic             burst_en_i,
    input  logic             irq_en_i,
    input  logic             test_en_i,
    input  logic             cp_sel_i,
    output logic [STAT_W-1:0] status_o,
    output logic             irq_pin_n_o
);
    mode_t mode;
    stat_t set_v, clr_v, st;
    logic [STAT_W-1:0] q;

    always_comb begin
        mode.burst  = burst_en_i;
        mode.irq_en = irq_en_i;
        mode.test   = test_en_i;
        mode.cp     = cp_sel_i;
    end

    xcvr_event_decode u_dec (
        .tx_done  (tx_done_i),
        .rx_load  (rx_load_i),
        .quiet_ok (quiet_ok_i),
        .tone_ok  (tone_ok_i),
        .rd_stb   (rd_stb_i),
        .mode     (mode),
        .set_v    (set_v),
        .clr_v    (clr_v)
    );

    xcvr_flag_bank #(.W(STAT_W), .RST_VAL('0)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .q     (q)
    );

    assign st       = stat_t'(q);
    assign status_o = q;

    xcvr_pin_mux u_pin (
        .st    (st),
        .mode  (mode),
        .pin_n (irq_pin_n_o)
    );
endmodule

// File: rtl/xcvr_flag_unit_chk.sv
module xcvr_flag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_done_i,
    input logic       rx_load_i,
    input logic       quiet_ok_i,
    input logic       tone_ok_i,
    input logic       rd_stb_i,
    input logic       burst_en_i,
    input logic       irq_en_i,
    input logic       test_en_i,
    input logic       cp_sel_i,
    input logic [3:0] status_o,
    input logic       irq_pin_n_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (status_o == 4'b0000));

    assert_rx_sets_R2: assert property (@(posedge clk) disable iff (rst)
        rx_load_i |=> (status_o[2] && status_o[0]));

    assert_tx_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_done_i && burst_en_i) |=> (status_o[1] && status_o[0]));

    assert_leave_burst_R4: assert property (@(posedge clk) disable iff (rst)
        !burst_en_i |=> !status_o[1]);

    assert_read_clears_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !rx_load_i) |=> !status_o[2]);

    assert_read_clears_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb_i && !rx_load_i && !(tx_done_i && burst_en_i)) |=> !status_o[0]);

    assert_irq_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[0]) |-> $past(rx_load_i || (tx_done_i && burst_en_i)));

    assert_steer_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!quiet_ok_i && !tone_ok_i) |=> $stable(status_o[3]));

    assert_steer_set_R7: assert property (@(posedge clk) disable iff (rst)
        quiet_ok_i |=> status_o[3]);

    assert_pin_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_i && !(test_en_i && !cp_sel_i)) |-> irq_pin_n_o);

    assert_pin_test_R9: assert property (@(posedge clk) disable iff (rst)
        (test_en_i && !cp_sel_i) |-> (irq_pin_n_o == !status_o[3]));

    assert_pin_cp_R10: assert property (@(posedge clk) disable iff (rst)
        cp_sel_i |-> (irq_pin_n_o == !(irq_en_i && status_o[0])));
endmodule

bind xcvr_flag_unit xcvr_flag_unit_chk u_chk (.*);

// File: tb/test_xcvr_flag_unit.sv
module test_xcvr_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_done_i = 0, rx_load_i = 0, quiet_ok_i = 0, tone_ok_i = 0, rd_stb_i = 0;
    logic burst_en_i = 0, irq_en_i = 0, test_en_i = 0, cp_sel_i = 0;
    logic [3:0] status_o;
    logic irq_pin_n_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_flag_unit i_xcvr_flag_unit (.*);

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic cleanup();
        burst_en_i = 0; irq_en_i = 0; test_en_i = 0; cp_sel_i = 0;
        rd_stb_i = 1; tone_ok_i = 1; tick();
        rd_stb_i = 0; tone_ok_i = 0; tick();
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick();
        chk("R1 status in reset", status_o, 4'b0000);
        chk("R1 pin in reset", {3'b0, irq_pin_n_o}, 4'b0001);
        rst = 0; tick();
        chk("R1 status after reset", status_o, 4'b0000);
    endtask

    task automatic t_rx_and_read();
        rx_load_i = 1; tick(); rx_load_i = 0;
        chk("R2 rx sets bits 2 and 0", status_o, 4'b0101);
        chk("R8 pin high with irq disabled", {3'b0, irq_pin_n_o}, 4'b0001);
        rd_stb_i = 1; settle();
        chk("R5 read returns old value", status_o, 4'b0101);
        tick(); rd_stb_i = 0;
        chk("R5 read clears", status_o, 4'b0000);
    endtask

    task automatic t_tx_burst();
        burst_en_i = 1; tx_done_i = 1; tick(); tx_done_i = 0;
        chk("R3 tx in burst sets bits 1 and 0", status_o, 4'b0011);
        burst_en_i = 0; tick();
        chk("R4 leaving burst clears bit 1 only", status_o, 4'b0001);
        cleanup();
    endtask

    task automatic t_tx_noburst();
        burst_en_i = 0; tx_done_i = 1; tick(); tx_done_i = 0;
        chk("R3 tx ignored without burst", status_o, 4'b0000);
    endtask

    task automatic t_collision();
        rd_stb_i = 1; rx_load_i = 1; tick(); rd_stb_i = 0; rx_load_i = 0;
        chk("R6 rx with read keeps set", status_o, 4'b0101);
        burst_en_i = 1; rd_stb_i = 1; tx_done_i = 1; tick();
        rd_stb_i = 0; tx_done_i = 0;
        chk("R6 tx with read: rx cleared, tx and irq set", status_o, 4'b0011);
        cleanup();
    endtask

    task automatic t_steer();
        quiet_ok_i = 1; tick(); quiet_ok_i = 0;
        chk("R7 quiet sets bit 3", status_o, 4'b1000);
        rd_stb_i = 1; tick(); rd_stb_i = 0;
        chk("R7 read leaves bit 3", status_o, 4'b1000);
        tone_ok_i = 1; tick(); tone_ok_i = 0;
        chk("R7 tone clears bit 3", status_o, 4'b0000);
        quiet_ok_i = 1; tone_ok_i = 1; tick(); quiet_ok_i = 0; tone_ok_i = 0;
        chk("R7 set wins over clear", status_o, 4'b1000);
        cleanup();
    endtask

    task automatic t_pin_normal();
        rx_load_i = 1; tick(); rx_load_i = 0;
        chk("R8 pin high, irq pending but disabled", {3'b0, irq_pin_n_o}, 4'b0001);
        irq_en_i = 1; settle();
        chk("R8 pin low when enabled and pending", {3'b0, irq_pin_n_o}, 4'b0000);
        rd_stb_i = 1; tick(); rd_stb_i = 0;
        chk("R8 pin high after read", {3'b0, irq_pin_n_o}, 4'b0001);
        cleanup();
    endtask

    task automatic t_pin_test();
        irq_en_i = 1; rx_load_i = 1; tick(); rx_load_i = 0;
        test_en_i = 1; cp_sel_i = 0; settle();
        chk("R9 pin shows inverted steer (0)", {3'b0, irq_pin_n_o}, 4'b0001);
        quiet_ok_i = 1; tick(); quiet_ok_i = 0;
        chk("R9 pin shows inverted steer (1)", {3'b0, irq_pin_n_o}, 4'b0000);
        irq_en_i = 0; settle();
        chk("R9 irq enable has no effect", {3'b0, irq_pin_n_o}, 4'b0000);
        irq_en_i = 1; cp_sel_i = 1; settle();
        chk("R10 cp mode follows irq", {3'b0, irq_pin_n_o}, 4'b0000);
        rd_stb_i = 1; tick(); rd_stb_i = 0;
        chk("R10 status after read", status_o, 4'b1000);
        chk("R10 pin high despite steer set", {3'b0, irq_pin_n_o}, 4'b0001);
        cleanup();
    endtask

    initial begin
        tick();
        t_reset();
        t_rx_and_read();
        t_tx_burst();
        t_tx_noburst();
        t_collision();
        t_steer();
        t_pin_normal();
        t_pin_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule